// File: doc/BRIEF.md
# Rewindable FIFO with programmable half-full threshold

This block is a single-clock first-in first-out buffer for 9-bit words. It holds its own storage array and drives three active-low status flags: full, empty and half-full. Words go in on an active-low write strobe and come out on an active-low read strobe. The read word is registered and appears on the data output after the clock edge that accepts the read.

The interface uses plain strobes in place of a valid/ready pair, and the flags carry the back-pressure:
- A write is taken only while the full flag is high. A write made while full is dropped.
- A read is taken only while the empty flag is high. A read made while empty is dropped, and the output word is kept.

An active-low rewind strobe moves the read position back to the first stored location without touching the write position, so the data written since reset can be read out again.

The reset input is synchronous and active low. While it is held low, the half-full threshold can be programmed:
- A write strobe copies the data input into the threshold register.
- A read strobe instead copies the word currently on the data output.

If neither strobe is used during a reset period, the threshold falls back to half the depth. The storage depth is 2^ADDR_W words.

Top module: `fifo_rewind`

## Requirements
- R1: Words are read back in the order they were written. A read strobe sampled low at a clock edge, with the empty flag high, puts the oldest stored 9-bit word on `dout` after that edge.
- R2: Starting from reset with no reads, `full_n` stays high for the first DEPTH-1 writes and goes low after exactly DEPTH writes. A write made while `full_n` is low stores nothing and moves no pointer.
- R3: `empty_n` is low whenever the stored count is zero. A read made while `empty_n` is low leaves `dout` and both pointers unchanged.
- R4: A low `rt_n` sampled with both `wr_n` and `rd_n` high moves the read position to the first location. The next read then returns the first word written since reset. The write position is kept, so later writes land after the existing data.
- R5: A low `rt_n` sampled while `wr_n` or `rd_n` is low is ignored. The strobe that is active still takes effect normally.
- R6: While `rst_n` is low, a low `wr_n` loads the threshold register from `din`.
- R7: While `rst_n` is low and `wr_n` is high, a low `rd_n` loads the threshold register from the present `dout` word.
- R8: If neither strobe is low during a reset period, the threshold is DEPTH/2. This holds even when an earlier reset period loaded a value.
- R9: `half_n` is low exactly when the stored count (writes minus reads) is strictly greater than the threshold.
- R10: After a rewind, `half_n` follows the count given by the rewound read position and the unchanged write position.
- R11: Leaving reset clears both pointers, so `empty_n` is low and `full_n` is high. A threshold loaded during that reset period is kept.
- R12: A write and a read accepted at the same edge leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; also opens threshold loading |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind strobe, active low |
| din | input | 9 | Write data, or threshold value during reset |
| dout | output | 9 | Registered read data |
| full_n | output | 1 | Low when DEPTH words are stored |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when the count exceeds the threshold |

## Verification
The hardest case to reach from the ports is loading the threshold from the output word. The bench first reads a known word so that it sits on `dout`, then holds reset and pulses the read strobe. It then confirms the loaded value by walking the count across it and watching `half_n`. The rewind cases need a read position ahead of the first location, so the bench writes, consumes part of the data and then rewinds. It checks that the flags jump back to the larger count and that the replayed words start at the first one written.

// File: rtl/fifo_rewind_pkg.sv
package fifo_rewind_pkg;
  localparam int DATA_W = 9;
  localparam int OFF_W  = 9;

  typedef logic [DATA_W-1:0] word_t;

  // width wide enough to compare a count against a loaded or default threshold
  function automatic int cmp_width(input int addr_w);
    return (addr_w + 1 > OFF_W) ? addr_w + 1 : OFF_W;
  endfunction
endpackage

// File: rtl/fifo_rewind_ptrs.sv
module fifo_rewind_ptrs #(
  parameter int ADDR_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            rt_n,
  input  logic            full_n,
  input  logic            empty_n,
  output logic            wr_go,
  output logic            rd_go,
  output logic [ADDR_W:0] wr_ptr,
  output logic [ADDR_W:0] rd_ptr
);
  logic rt_go;

  always_comb begin
    wr_go = rst_n & ~wr_n & full_n;
    rd_go = rst_n & ~rd_n & empty_n;
    rt_go = rst_n & ~rt_n & wr_n & rd_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + 1'b1;
      if (rt_go) rd_ptr <= '0;
      else if (rd_go) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/fifo_rewind_mem.sv
module fifo_rewind_mem
  import fifo_rewind_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ADDR_W-1:0] raddr,
  input  word_t             din,
  output word_t             dout
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_go) store[waddr] <= din;
    if (rd_go) dout <= store[raddr];
  end
endmodule

// File: rtl/fifo_rewind_offset.sv
module fifo_rewind_offset
  import fifo_rewind_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int CW = cmp_width(ADDR_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  word_t         din,
  input  word_t         dout,
  output logic [CW-1:0] thresh
);
  localparam logic [CW-1:0] HALF = CW'(1) << (ADDR_W - 1);

  logic load_w, load_r, held;

  always_comb begin
    load_w = ~rst_n & ~wr_n;
    load_r = ~rst_n & wr_n & ~rd_n;
  end

  // held marks a load earlier in the current reset period; it blocks the default
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (load_w) begin
        thresh <= CW'(din);
        held   <= 1'b1;
      end else if (load_r) begin
        thresh <= CW'(dout);
        held   <= 1'b1;
      end else if (held) begin
        thresh <= thresh;
      end else begin
        thresh <= HALF;
      end
    end else begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_rewind_flags.sv
module fifo_rewind_flags
  import fifo_rewind_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int CW = cmp_width(ADDR_W)
) (
  input  logic [ADDR_W:0] wr_ptr,
  input  logic [ADDR_W:0] rd_ptr,
  input  logic [CW-1:0]   thresh,
  output logic [ADDR_W:0] fill,
  output logic            full_n,
  output logic            empty_n,
  output logic            half_n
);
  localparam logic [ADDR_W:0] FULL_CNT = {1'b1, {ADDR_W{1'b0}}};

  always_comb begin
    fill    = wr_ptr - rd_ptr;
    full_n  = (fill != FULL_CNT);
    empty_n = (fill != '0);
    half_n  = !(CW'(fill) > thresh);
  end
endmodule

// File: rtl/fifo_rewind.sv
module fifo_rewind
  import fifo_rewind_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n
);
  localparam int CW = cmp_width(ADDR_W);

  logic            wr_go, rd_go;
  logic [ADDR_W:0] wr_ptr, rd_ptr, fill;
  logic [CW-1:0]   thresh;

  fifo_rewind_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .full_n(full_n), .empty_n(empty_n),
    .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  fifo_rewind_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_go(wr_go), .rd_go(rd_go),
    .waddr(wr_ptr[ADDR_W-1:0]), .raddr(rd_ptr[ADDR_W-1:0]),
    .din(din), .dout(dout)
  );

  fifo_rewind_offset #(.ADDR_W(ADDR_W)) u_off (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .thresh(thresh)
  );

  fifo_rewind_flags #(.ADDR_W(ADDR_W)) u_flags (
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .thresh(thresh), .fill(fill),
    .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
  );
endmodule

// File: rtl/fifo_rewind_chk.sv
module fifo_rewind_chk #(
  parameter int ADDR_W = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_n,
  input logic            rd_n,
  input logic            rt_n,
  input logic [8:0]      dout,
  input logic            full_n,
  input logic            empty_n,
  input logic            half_n,
  input logic [ADDR_W:0] wr_ptr,
  input logic [ADDR_W:0] rd_ptr,
  input logic [ADDR_W:0] fill
);
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n && rd_n) |=> !full_n); // R2
  AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_n) |=> $stable(dout)); // R3
  AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n)); // R3
  AST_RT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n && wr_n && rd_n) |=> (rd_ptr == '0)); // R4
  AST_RT_KEEPS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_n && wr_n && rd_n) |=> $stable(wr_ptr)); // R4
  AST_HALF_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!empty_n && full_n)); // R11
  AST_BOTH_KEEP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !rd_n && full_n && empty_n) |=> $stable(fill)); // R12
endmodule

bind fifo_rewind fifo_rewind_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
  .dout(dout), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill)
);

// File: tb/fifo_rewind_bench.sv
module fifo_rewind_bench;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       full_n, empty_n, half_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fifo_rewind #(.ADDR_W(AW)) u_fifo_rewind (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: no load, 1: load from din, 2: load from dout
  task automatic do_reset(input int mode, input logic [8:0] v);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    tick();
    if (mode == 1) begin din = v; wr_n = 1'b0; tick(); wr_n = 1'b1; end
    if (mode == 2) begin rd_n = 1'b0; tick(); rd_n = 1'b1; end
    tick();
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [8:0] v);
    din = v; wr_n = 1'b0; tick(); wr_n = 1'b1;
  endtask

  task automatic pop();
    rd_n = 1'b0; tick(); rd_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(0, '0);
    check("R11 empty after reset", empty_n, 0);
    check("R11 full high after reset", full_n, 1);
    check("R9 half high after reset", half_n, 1);
  endtask

  task automatic t_order();
    do_reset(0, '0);
    for (int i = 1; i <= 5; i++) push(9'(i * 37));
    for (int i = 1; i <= 5; i++) begin
      pop();
      check("R1 read order", dout, (i * 37) & 9'h1FF);
    end
    check("R3 empty after drain", empty_n, 0);
    pop();
    check("R3 read while empty keeps dout", dout, 185);
    push(9'h011);
    pop();
    check("R3 pointer unmoved by dropped read", dout, 9'h011);
  endtask

  task automatic t_fill();
    do_reset(0, '0);
    for (int i = 0; i < DEPTH; i++) begin
      push(9'(i + 100));
      if (i == DEPTH / 2 - 1) check("R8 half high at default threshold", half_n, 1);
      if (i == DEPTH / 2) check("R8 half low above default threshold", half_n, 0);
      if (i == DEPTH - 2) check("R2 full high before last write", full_n, 1);
    end
    check("R2 full low after DEPTH writes", full_n, 0);
    push(9'h1FF);
    check("R2 still full after dropped write", full_n, 0);
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      check("R2 contents unaffected by dropped write", dout, i + 100);
    end
    check("R2 empty after full drain", empty_n, 0);
  endtask

  task automatic t_rewind();
    do_reset(0, '0);
    push(9'd10); push(9'd11); push(9'd12);
    pop(); pop();
    check("R1 second word", dout, 11);
    rt_n = 1'b0; tick(); rt_n = 1'b1;
    pop();
    check("R4 rewind replays first word", dout, 10);
    push(9'd13);
    pop(); check("R4 replay second", dout, 11);
    pop(); check("R4 replay third", dout, 12);
    pop(); check("R4 write position kept", dout, 13);
    check("R4 empty after replay", empty_n, 0);
  endtask

  task automatic t_rewind_blocked();
    do_reset(0, '0);
    push(9'h0A); push(9'h0B);
    pop();
    rt_n = 1'b0; rd_n = 1'b0; tick(); rt_n = 1'b1; rd_n = 1'b1;
    check("R5 read taken with rewind low", dout, 9'h0B);
    check("R5 rewind ignored during read", empty_n, 0);
    din = 9'h0C; rt_n = 1'b0; wr_n = 1'b0; tick(); rt_n = 1'b1; wr_n = 1'b1;
    pop();
    check("R5 rewind ignored during write", dout, 9'h0C);
    check("R5 empty after single word", empty_n, 0);
  endtask

  task automatic t_load_din();
    do_reset(1, 9'd3);
    check("R11 empty after loading reset", empty_n, 0);
    push(1); push(2); push(3);
    check("R6 count equal threshold", half_n, 1);
    push(4);
    check("R6 count above threshold", half_n, 0);
    pop();
    check("R9 back to threshold", half_n, 1);
  endtask

  task automatic t_simul();
    do_reset(1, 9'd2);
    push(1); push(2); push(3);
    check("R9 count 3 above 2", half_n, 0);
    din = 9'd4; wr_n = 1'b0; rd_n = 1'b0; tick(); wr_n = 1'b1; rd_n = 1'b1;
    check("R12 read part of joint cycle", dout, 1);
    check("R12 count kept", half_n, 0);
    pop(); check("R12 next word", dout, 2);
    check("R12 count two at threshold", half_n, 1);
    pop(); check("R12 next word", dout, 3);
    pop(); check("R12 written word", dout, 4);
    check("R12 empty", empty_n, 0);
  endtask

  task automatic t_load_dout();
    // dout is 4 from the previous scenario
    do_reset(2, 9'd0);
    check("R11 empty after reset", empty_n, 0);
    for (int i = 0; i < 4; i++) push(9'(i));
    check("R7 count at threshold from dout", half_n, 1);
    push(9'd9);
    check("R7 count above threshold from dout", half_n, 0);
  endtask

  task automatic t_default_again();
    do_reset(0, '0);
    for (int i = 0; i < DEPTH / 2; i++) push(9'(i));
    check("R8 default restored after earlier load", half_n, 1);
    push(9'd1);
    check("R8 above default", half_n, 0);
  endtask

  task automatic t_rewind_half();
    do_reset(1, 9'd2);
    push(20); push(21); push(22); push(23);
    pop(); pop(); pop();
    check("R9 one word stored", half_n, 1);
    rt_n = 1'b0; tick(); rt_n = 1'b1;
    check("R10 half low after rewind", half_n, 0);
    pop();
    check("R4 first word after rewind", dout, 20);
    check("R10 still above threshold", half_n, 0);
  endtask

  initial begin
    t_reset_state();
    t_order();
    t_fill();
    t_rewind();
    t_rewind_blocked();
    t_load_din();
    t_simul();
    t_load_dout();
    t_default_again();
    t_rewind_half();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule